// File: doc/BRIEF.md
# Augmented-Message CRC-16 Engine

This block computes a 16-bit cyclic redundancy code over a byte stream using the long-division form of the algorithm. A 16-bit remainder register takes in one message bit per clock, most significant bit first. Each step shifts the register left by one and puts the new bit in at bit 0. When the bit that leaves the top position is a one, the shifted register is XORed with the generator mask 0x8005. That mask stands for x^16 + x^15 + x^2 + 1, with the x^16 term implied. All arithmetic is modulo-2, so every subtraction is an XOR.

There are two modes, and both use this same datapath. In generate mode, the engine pushes sixteen zero bits through the register after the final byte. The remainder left at the end is the code to append to the message, high byte first. In check mode, no padding is added. The received message is fed in together with its two code bytes, and a remainder of zero means the message arrived intact. The register starts each message at zero and every byte is shifted in, so any whole number of bytes from one upward is accepted.

Bytes enter through a valid/ready handshake with a last-byte marker. The mode input is sampled with each accepted byte and must stay steady for the whole message. A synchronous clear input abandons any message in progress.

Top module: `crc16_aug_engine`

## Requirements
- R1: After reset, in_ready is 1, and done, error and crc are all 0.
- R2: In generate mode (mode = 0), crc at the done pulse equals the remainder of M·x^16 divided by x^16+x^15+x^2+1 (mask 0x8005), with message bytes taken most significant bit first. For the ASCII bytes "123456789" the result is 0xFEE8.
- R3: In check mode (mode = 1), a message followed by its generated code (high byte, then low byte) gives done with error = 0 and crc = 0x0000.
- R4: In check mode, a message whose final remainder is nonzero gives error = 1 in the same cycle as done, and crc holds that nonzero remainder.
- R5: After a non-final byte is accepted, in_ready is low for exactly 8 cycles and is high again in the 9th.
- R6: done rises 8 cycles after the acceptance edge of the final byte in check mode, and 24 cycles after it in generate mode. In both cases in_ready rises in that same cycle.
- R7: done is a one-cycle pulse, and error is never 1 while done is 0.
- R8: A cycle with clear = 1 abandons the message in progress and returns in_ready to 1 without a done pulse. The next message is computed from a zero register.
- R9: A message of exactly one byte is processed correctly in both modes.
- R10: in_valid, in_data and in_last are ignored while in_ready is low.
- R11: crc keeps its value from one done pulse until the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous abandon of the current message |
| mode | input | 1 | 0 = generate (pad 16 zero bits), 1 = check |
| in_valid | input | 1 | Input byte is valid |
| in_data | input | 8 | Message byte, shifted most significant bit first |
| in_last | input | 1 | Marks the final byte of the message |
| in_ready | output | 1 | Engine can accept a byte |
| done | output | 1 | One-cycle pulse when the final remainder is ready |
| crc | output | 16 | Final remainder, held until the next done pulse |
| error | output | 1 | With done in check mode: remainder was nonzero |

## Verification
The bench builds the engine with its default parameters: 8-bit bytes, a 16-bit register and the 0x8005 mask. At this size, every possible single-byte message can be swept in both modes. Each generated code is fed back in check mode, and then again with one bit flipped, and the flipped bit moves through every position of the three checked bytes. Expected remainders come from a bench-side direct-form bit-serial calculation, which avoids the augmented datapath entirely, so any error in the padding count or in the feedback taps shows up as a mismatch. Junk driven on the inputs while the engine is busy, together with clears issued between bytes and in the middle of a shift, covers the handshake and abandon paths.

// File: rtl/crc_aug_pkg.sv
package crc_aug_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_PAD   = 2'd2
   } eng_state_t;

   typedef enum logic {
      MODE_GEN = 1'b0,
      MODE_CHK = 1'b1
   } eng_mode_t;

endpackage

// File: rtl/crc_aug_step.sv
module crc_aug_step #(
   parameter int                CRC_W = 16,
   parameter logic [CRC_W-1:0]  POLY  = 16'h8005
) (
   input  logic [CRC_W-1:0] rem_i,
   input  logic             bit_i,
   output logic [CRC_W-1:0] rem_o
);

   logic top_bit;
   assign top_bit = rem_i[CRC_W-1];

   // one long-division step: shift left, new bit at bit 0, subtract mask if top bit left
   for (genvar i = 0; i < CRC_W; i++) begin : g_bit
      if (i == 0) begin : g_lsb
         assign rem_o[i] = bit_i ^ (POLY[i] & top_bit);
      end else begin : g_upper
         assign rem_o[i] = rem_i[i-1] ^ (POLY[i] & top_bit);
      end
   end

endmodule

// File: rtl/crc_aug_ctrl.sv
module crc_aug_ctrl
   import crc_aug_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CRC_W  = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic in_valid,
   input  logic in_last,
   input  logic mode,
   output logic in_ready,
   output logic load_byte,
   output logic shift_en,
   output logic feed_zero,
   output logic finish,
   output logic chk_mode
);

   localparam int MAX_W = (DATA_W > CRC_W) ? DATA_W : CRC_W;
   localparam int CNT_W = $clog2(MAX_W) + 1;
   localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0] PAD_LAST  = CNT_W'(CRC_W - 1);

   eng_state_t       state_q;
   eng_mode_t        mode_q;
   logic [CNT_W-1:0] cnt_q;
   logic             last_q;
   logic             step_final;

   always_comb begin
      in_ready   = (state_q == ST_IDLE);
      load_byte  = in_valid && in_ready && !clear;
      shift_en   = (state_q != ST_IDLE);
      feed_zero  = (state_q == ST_PAD);
      step_final = shift_en && (cnt_q == '0);
      finish     = step_final && !clear &&
                   ((state_q == ST_PAD) || (last_q && mode_q == MODE_CHK));
      chk_mode   = (mode_q == MODE_CHK);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mode_q  <= MODE_GEN;
         cnt_q   <= '0;
         last_q  <= 1'b0;
      end else if (clear) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         last_q  <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (load_byte) begin
                  state_q <= ST_SHIFT;
                  cnt_q   <= BYTE_LAST;
                  last_q  <= in_last;
                  mode_q  <= eng_mode_t'(mode);
               end
            end
            ST_SHIFT: begin
               if (cnt_q == '0) begin
                  if (last_q && mode_q == MODE_GEN) begin
                     state_q <= ST_PAD;
                     cnt_q   <= PAD_LAST;
                  end else begin
                     state_q <= ST_IDLE;
                  end
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_PAD: begin
               if (cnt_q == '0) begin
                  state_q <= ST_IDLE;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/crc_aug_datapath.sv
module crc_aug_datapath #(
   parameter int               DATA_W = 8,
   parameter int               CRC_W  = 16,
   parameter logic [CRC_W-1:0] POLY   = 16'h8005
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic [DATA_W-1:0] in_data,
   input  logic              load_byte,
   input  logic              shift_en,
   input  logic              feed_zero,
   input  logic              finish,
   input  logic              chk_mode,
   output logic [CRC_W-1:0]  crc_o,
   output logic              done_o,
   output logic              error_o
);

   logic [DATA_W-1:0] byte_q;
   logic [CRC_W-1:0]  work_q;
   logic [CRC_W-1:0]  work_nxt;
   logic [CRC_W-1:0]  res_q;
   logic              done_q;
   logic              error_q;
   logic              bit_in;

   assign bit_in = feed_zero ? 1'b0 : byte_q[DATA_W-1];

   crc_aug_step #(
      .CRC_W (CRC_W),
      .POLY  (POLY)
   ) step_i (
      .rem_i (work_q),
      .bit_i (bit_in),
      .rem_o (work_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_q <= '0;
      end else if (load_byte) begin
         byte_q <= in_data;
      end else if (shift_en && !feed_zero) begin
         byte_q <= byte_q << 1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         work_q <= '0;
      end else if (clear || finish) begin
         work_q <= '0;
      end else if (shift_en) begin
         work_q <= work_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q <= '0;
      end else if (finish) begin
         res_q <= work_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q  <= 1'b0;
         error_q <= 1'b0;
      end else if (clear) begin
         done_q  <= 1'b0;
         error_q <= 1'b0;
      end else begin
         done_q  <= finish;
         error_q <= finish && chk_mode && (work_nxt != '0);
      end
   end

   assign crc_o   = res_q;
   assign done_o  = done_q;
   assign error_o = error_q;

endmodule

// File: rtl/crc16_aug_engine.sv
module crc16_aug_engine #(
   parameter int               DATA_W = 8,
   parameter int               CRC_W  = 16,
   parameter logic [CRC_W-1:0] POLY   = 16'h8005
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              mode,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_last,
   output logic              in_ready,
   output logic              done,
   output logic [CRC_W-1:0]  crc,
   output logic              error
);

   if (DATA_W < 1) begin : g_bad_data_w
      $error("DATA_W must be at least 1");
   end
   if (CRC_W < 2) begin : g_bad_crc_w
      $error("CRC_W must be at least 2");
   end
   if (POLY[0] != 1'b1) begin : g_bad_poly
      $error("POLY must have its constant term set");
   end

   logic load_byte;
   logic shift_en;
   logic feed_zero;
   logic finish;
   logic chk_mode;

   crc_aug_ctrl #(
      .DATA_W (DATA_W),
      .CRC_W  (CRC_W)
   ) ctrl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (clear),
      .in_valid  (in_valid),
      .in_last   (in_last),
      .mode      (mode),
      .in_ready  (in_ready),
      .load_byte (load_byte),
      .shift_en  (shift_en),
      .feed_zero (feed_zero),
      .finish    (finish),
      .chk_mode  (chk_mode)
   );

   crc_aug_datapath #(
      .DATA_W (DATA_W),
      .CRC_W  (CRC_W),
      .POLY   (POLY)
   ) dp_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (clear),
      .in_data   (in_data),
      .load_byte (load_byte),
      .shift_en  (shift_en),
      .feed_zero (feed_zero),
      .finish    (finish),
      .chk_mode  (chk_mode),
      .crc_o     (crc),
      .done_o    (done),
      .error_o   (error)
   );

endmodule

// File: rtl/crc16_aug_engine_chk.sv
module crc16_aug_engine_chk #(
   parameter int DATA_W = 8,
   parameter int CRC_W  = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clear,
   input logic             in_valid,
   input logic             in_ready,
   input logic             done,
   input logic [CRC_W-1:0] crc,
   input logic             error
);

   localparam int BUSY_MAX = DATA_W + CRC_W;
   localparam int BUSY_W   = $clog2(BUSY_MAX + 2) + 1;

   logic [BUSY_W-1:0] busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_run <= '0;
      end else if (in_ready) begin
         busy_run <= '0;
      end else if (busy_run <= BUSY_W'(BUSY_MAX)) begin
         busy_run <= busy_run + 1'b1;
      end
   end

   a_r5_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !clear) |=> !in_ready);

   a_r6_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      busy_run <= BUSY_W'(BUSY_MAX));

   a_r6_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> in_ready);

   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r7_error_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> done);

   a_r4_error_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> (crc != '0));

   a_r8_clear_idles: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (in_ready && !done));

   a_r11_crc_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(crc));

endmodule

bind crc16_aug_engine crc16_aug_engine_chk #(
   .DATA_W (DATA_W),
   .CRC_W  (CRC_W)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .clear    (clear),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .done     (done),
   .crc      (crc),
   .error    (error)
);

// File: tb/crc16_aug_engine_tb_top.sv
`timescale 1ns/1ps
module crc16_aug_engine_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        clear;
   logic        mode;
   logic        in_valid;
   logic [7:0]  in_data;
   logic        in_last;
   logic        in_ready;
   logic        done;
   logic [15:0] crc;
   logic        error;

   int checks = 0;
   int errors = 0;

   logic [7:0]  msg [0:31];
   int          mlen;
   logic [15:0] got_crc;
   logic        got_err;
   logic        got_done;
   logic        early_done;
   int          got_wait;

   always #2 clk = ~clk;

   crc16_aug_engine dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (clear),
      .mode     (mode),
      .in_valid (in_valid),
      .in_data  (in_data),
      .in_last  (in_last),
      .in_ready (in_ready),
      .done     (done),
      .crc      (crc),
      .error    (error)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // direct-form bit-serial model: feedback = top bit XOR incoming bit
   function automatic logic [15:0] crc_ref(input int n);
      logic [15:0] c = 16'h0000;
      for (int i = 0; i < n; i++) begin
         for (int b = 7; b >= 0; b--) begin
            logic fb = c[15] ^ msg[i][b];
            c = {c[14:0], 1'b0} ^ (fb ? 16'h8005 : 16'h0000);
         end
      end
      return c;
   endfunction

   // called at a negedge; returns at the negedge where in_ready is high again
   task automatic send_byte(input logic [7:0] d, input bit last);
      in_data  = d;
      in_last  = last;
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      // R10: junk on the inputs while the engine is busy
      in_data  = ~d;
      in_last  = ~last;
      in_valid = 1'b1;
      got_wait   = 0;
      early_done = 1'b0;
      while (!in_ready) begin
         if (done) early_done = 1'b1;
         @(negedge clk);
         got_wait++;
      end
      got_done = done;
      got_err  = error;
      got_crc  = crc;
      in_valid = 1'b0;
      in_last  = 1'b0;
   endtask

   task automatic run_msg(input bit chk_m);
      mode = chk_m;
      for (int i = 0; i < mlen; i++) begin
         send_byte(msg[i], i == mlen - 1);
         if (i != mlen - 1) begin
            check(got_wait == 8, "R5", "busy cycles per byte", got_wait, 8);
            check(!got_done, "R5", "no done mid-message", got_done, 0);
         end else begin
            check(got_wait == (chk_m ? 8 : 24), "R6", "cycles to done",
                  got_wait, chk_m ? 8 : 24);
            check(got_done && !early_done, "R7", "done pulse at end",
                  {early_done, got_done}, 1);
         end
      end
   endtask

   task automatic load_ascii();
      for (int i = 0; i < 9; i++) msg[i] = 8'h31 + 8'(i);
      mlen = 9;
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R6 watchdog expired actual=0 expected=1");
      finish_run();
   end

   initial begin
      logic [15:0] exp_c;
      logic        saw_done;
      rst_n = 1'b0; clear = 1'b0; mode = 1'b0;
      in_valid = 1'b0; in_data = 8'h00; in_last = 1'b0;
      repeat (3) @(negedge clk);
      // R1
      check(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
      check(done == 1'b0, "R1", "done in reset", done, 0);
      check(error == 1'b0, "R1", "error in reset", error, 0);
      check(crc == 16'h0, "R1", "crc in reset", crc, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 known vector
      load_ascii();
      run_msg(1'b0);
      check(got_crc == 16'hFEE8, "R2", "ascii vector", got_crc, 16'hFEE8);
      check(got_crc == crc_ref(9), "R2", "model match", got_crc, crc_ref(9));
      @(negedge clk);
      check(done == 1'b0, "R7", "done drops", done, 0);
      check(error == 1'b0, "R7", "error low without done", error, 0);
      repeat (5) @(negedge clk);
      check(crc == 16'hFEE8, "R11", "crc held", crc, 16'hFEE8);

      // R3 check of ascii + code
      msg[9] = 8'hFE; msg[10] = 8'hE8; mlen = 11;
      run_msg(1'b1);
      check(!got_err, "R3", "clean check error", got_err, 0);
      check(got_crc == 16'h0, "R3", "clean remainder", got_crc, 0);

      // R4 corrupted byte
      msg[4] = msg[4] ^ 8'h10;
      run_msg(1'b1);
      check(got_err, "R4", "corrupt flagged", got_err, 1);
      check(got_crc != 16'h0, "R4", "nonzero remainder", got_crc, 1);

      // R9 sweep of all one-byte messages, with check and single-bit errors
      for (int v = 0; v < 256; v++) begin
         msg[0] = 8'(v); mlen = 1;
         exp_c = crc_ref(1);
         run_msg(1'b0);
         check(got_crc == exp_c, "R9", "one-byte generate", got_crc, exp_c);
         msg[1] = exp_c[15:8]; msg[2] = exp_c[7:0]; mlen = 3;
         run_msg(1'b1);
         check(!got_err && got_crc == 16'h0, "R3", "one-byte check",
               {got_err, got_crc}, 0);
         msg[v % 3] = msg[v % 3] ^ (8'h01 << (v % 8));
         run_msg(1'b1);
         check(got_err, "R4", "single-bit flip flagged", got_err, 1);
      end

      // R2 two-byte messages
      for (int v = 0; v < 64; v++) begin
         msg[0] = 8'(v * 37); msg[1] = 8'(v) ^ 8'hA5; mlen = 2;
         exp_c = crc_ref(2);
         run_msg(1'b0);
         check(got_crc == exp_c, "R2", "two-byte generate", got_crc, exp_c);
      end

      // R8 clear between bytes
      mode = 1'b0;
      send_byte(8'hAA, 1'b0);
      send_byte(8'h55, 1'b0);
      clear = 1'b1;
      @(negedge clk);
      clear = 1'b0;
      load_ascii();
      run_msg(1'b0);
      check(got_crc == 16'hFEE8, "R8", "fresh after clear", got_crc, 16'hFEE8);

      // R8 clear mid-shift of a final byte
      mode = 1'b0; in_data = 8'hFF; in_last = 1'b1; in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
      repeat (2) @(negedge clk);
      clear = 1'b1;
      @(negedge clk);
      clear = 1'b0;
      check(in_ready == 1'b1, "R8", "ready after clear", in_ready, 1);
      saw_done = 1'b0;
      for (int i = 0; i < 30; i++) begin
         if (done) saw_done = 1'b1;
         @(negedge clk);
      end
      check(!saw_done, "R8", "no done after clear", saw_done, 0);
      check(crc == 16'hFEE8, "R11", "crc kept across clear", crc, 16'hFEE8);
      load_ascii();
      run_msg(1'b0);
      check(got_crc == 16'hFEE8, "R8", "fresh after mid clear", got_crc, 16'hFEE8);

      finish_run();
   end

endmodule